// File: doc/BRIEF.md
# Bus Address Breakpoint Unit

This debug block sits beside a small 8-bit CPU and watches its 16-bit address bus. Software loads a breakpoint address into two byte-wide registers and sets an enable bit. On any cycle where the bus strobe marks the address as valid and that address equals the breakpoint, the unit latches a break-active flag. The break interrupt output follows that flag as a level. The flag stays set until software writes 0 to it. Software can also raise the break directly by writing 1 to the flag, whether or not the comparator is enabled.

The unit is aware of the CPU's low-power states. In wait mode the comparator keeps running. In stop mode it is held off, and no register changes. If the break flag becomes set while either low-power input is high, a separate exit-status bit records that the break ended the low-power state. Software reads that bit and clears it through the same register port.

The register port is a plain byte-wide select/write/read interface. A write takes effect on the clock edge where the write strobe is high. Reads are combinational from the select lines. The port always accepts, so there is no back-pressure. Every other pin is a plain level.

Top module: `bkpt_unit`

## Requirements
- R1: Register select 0 is control/status, with bit 0 = enable and bit 1 = break-active flag. Select 1 is the upper breakpoint byte (address bits 15..8). Select 2 is the lower byte (bits 7..0). Select 3 is the exit status, with bit 0 = exit flag. Unused bits read 0, and reads are combinational from the select lines.
- R2: After reset, both breakpoint bytes, the enable bit, the break flag and the exit flag are 0, and `brk_irq` is low.
- R3: With enable set, a cycle in which `bus_valid` is high, `stop_mode` is low and `bus_addr` equals the breakpoint sets the break flag at that clock edge.
- R4: A cycle with `bus_valid` low, or with an address that differs from the breakpoint, does not set the flag.
- R5: Writing a 1 to control bit 1 sets the break flag and raises `brk_irq` even when enable is 0.
- R6: The break flag holds until a control write puts 0 in bit 1. If that write and a match fall in the same cycle, the match wins and the flag stays set.
- R7: With enable at 0, a matching valid address never sets the flag.
- R8: `wait_mode` does not gate the comparator; a match during wait sets the flag.
- R9: While `stop_mode` is high no match sets the flag, and the breakpoint, control and status contents are left unchanged.
- R10: When the break flag goes from 0 to 1 while `wait_mode` or `stop_mode` is high, the exit flag (`lp_exit`) sets. It is cleared only by reset or by writing 0 to status bit 0. Writing 1 to it has no effect. A break outside low-power modes leaves it at 0.
- R11: `brk_irq` is a level that is high exactly while the break flag is set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_sel | input | 2 | Register select |
| reg_wr | input | 1 | Register write strobe |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Register read data (combinational) |
| bus_addr | input | 16 | CPU address bus |
| bus_valid | input | 1 | Address-valid strobe |
| wait_mode | input | 1 | CPU is in wait mode |
| stop_mode | input | 1 | CPU is in stop mode |
| brk_irq | output | 1 | Break interrupt level |
| lp_exit | output | 1 | Break-ended-low-power status |

## Verification
A wrong breakpoint byte or enable bit shows up on the first matching valid cycle: `brk_irq` either fails to rise, or rises on the wrong address one edge later. It also shows up at once on a register read. A flag that clears by itself, or ignores the match-over-clear priority, drops `brk_irq` on the edge after the offending cycle. A broken low-power path shows in one of two ways, both on the same edge that the flag sets. Either `lp_exit` stays low after a break taken during wait or stop, or it sets after a break taken in normal run.

// File: rtl/bkpt_pkg.sv
package bkpt_pkg;
  // control/status register bit positions
  localparam int CTRL_EN_BIT  = 0;
  localparam int CTRL_ACT_BIT = 1;
  // exit status register bit position
  localparam int STAT_EXIT_BIT = 0;
  // control register is always at select 0
  localparam int SEL_CTRL = 0;
endpackage

// File: rtl/bkpt_match.sv
module bkpt_match #(
  parameter int ADDR_W = 16
) (
  input  logic              enable,
  input  logic              stop_mode,
  input  logic              bus_valid,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [ADDR_W-1:0] bkpt_addr,
  output logic              hit
);
  logic addr_eq;
  logic gate_open;

  // comparator runs in run and wait modes, is held off in stop
  assign addr_eq   = (bus_addr == bkpt_addr);
  assign gate_open = enable && bus_valid && !stop_mode;
  assign hit       = gate_open && addr_eq;
endmodule

// File: rtl/bkpt_lpstat.sv
module bkpt_lpstat (
  input  logic clk,
  input  logic rst_n,
  input  logic act_rise,
  input  logic wait_mode,
  input  logic stop_mode,
  input  logic exit_clr,
  output logic exit_flag
);
  logic in_lp;
  logic set_evt;

  assign in_lp   = wait_mode || stop_mode;
  assign set_evt = act_rise && in_lp;

  // set has priority over a software clear in the same cycle
  always_ff @(posedge clk) begin
    if (!rst_n)        exit_flag <= 1'b0;
    else if (set_evt)  exit_flag <= 1'b1;
    else if (exit_clr) exit_flag <= 1'b0;
  end

  // R10
  exit_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (act_rise && (wait_mode || stop_mode)) |=> exit_flag);

  // R10
  exit_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (exit_flag && !exit_clr) |=> exit_flag);
endmodule

// File: rtl/bkpt_regs.sv
module bkpt_regs
  import bkpt_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int DATA_W = 8,
  parameter int NBYTES = ADDR_W / DATA_W,
  parameter int SEL_W  = $clog2(NBYTES + 2)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [SEL_W-1:0]  reg_sel,
  input  logic              reg_wr,
  input  logic [DATA_W-1:0] reg_wdata,
  input  logic              hit,
  input  logic              exit_flag,
  output logic [DATA_W-1:0] reg_rdata,
  output logic [ADDR_W-1:0] bkpt_addr,
  output logic              enable,
  output logic              active,
  output logic              act_rise,
  output logic              exit_clr
);
  localparam int SEL_STAT = NBYTES + 1;

  logic [NBYTES-1:0][DATA_W-1:0] byte_q;
  logic ctrl_wr;
  logic force_set;
  logic sw_clear;
  logic act_next;

  assign ctrl_wr   = reg_wr && (reg_sel == SEL_W'(SEL_CTRL));
  assign force_set = ctrl_wr && reg_wdata[CTRL_ACT_BIT];
  assign sw_clear  = ctrl_wr && !reg_wdata[CTRL_ACT_BIT];
  assign exit_clr  = reg_wr && (reg_sel == SEL_W'(SEL_STAT)) && !reg_wdata[STAT_EXIT_BIT];

  // byte b holds address bits [b*DATA_W +: DATA_W]; the upper byte sits at select 1
  for (genvar b = 0; b < NBYTES; b++) begin : g_byte
    localparam int SEL_B = NBYTES - b;
    always_ff @(posedge clk) begin
      if (!rst_n)
        byte_q[b] <= '0;
      else if (reg_wr && (reg_sel == SEL_W'(SEL_B)))
        byte_q[b] <= reg_wdata;
    end
  end

  assign bkpt_addr = byte_q;

  always_ff @(posedge clk) begin
    if (!rst_n)       enable <= 1'b0;
    else if (ctrl_wr) enable <= reg_wdata[CTRL_EN_BIT];
  end

  // a match outranks a software clear in the same cycle
  always_comb begin
    act_next = active;
    if (hit || force_set) act_next = 1'b1;
    else if (sw_clear)    act_next = 1'b0;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) active <= 1'b0;
    else        active <= act_next;
  end

  assign act_rise = act_next && !active;

  always_comb begin
    reg_rdata = '0;
    if (reg_sel == SEL_W'(SEL_CTRL)) begin
      reg_rdata[CTRL_EN_BIT]  = enable;
      reg_rdata[CTRL_ACT_BIT] = active;
    end
    if (reg_sel == SEL_W'(SEL_STAT))
      reg_rdata[STAT_EXIT_BIT] = exit_flag;
    for (int b = 0; b < NBYTES; b++)
      if (reg_sel == SEL_W'(NBYTES - b))
        reg_rdata = byte_q[b];
  end

  // R3
  hit_sets_chk: assert property (@(posedge clk) disable iff (!rst_n)
    hit |=> active);

  // R5
  force_sets_chk: assert property (@(posedge clk) disable iff (!rst_n)
    force_set |=> active);

  // R6
  flag_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (active && !sw_clear) |=> active);

  // R7
  enable_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!enable && !active && !force_set) |=> !active);
endmodule

// File: rtl/bkpt_unit.sv
module bkpt_unit #(
  parameter int ADDR_W = 16,
  parameter int DATA_W = 8,
  parameter int NBYTES = ADDR_W / DATA_W,
  parameter int SEL_W  = $clog2(NBYTES + 2)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [SEL_W-1:0]  reg_sel,
  input  logic              reg_wr,
  input  logic [DATA_W-1:0] reg_wdata,
  output logic [DATA_W-1:0] reg_rdata,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_valid,
  input  logic              wait_mode,
  input  logic              stop_mode,
  output logic              brk_irq,
  output logic              lp_exit
);
  logic [ADDR_W-1:0] bkpt_addr;
  logic enable;
  logic active;
  logic act_rise;
  logic exit_clr;
  logic exit_flag;
  logic hit;

  bkpt_match #(.ADDR_W(ADDR_W)) u_match (
    .enable    (enable),
    .stop_mode (stop_mode),
    .bus_valid (bus_valid),
    .bus_addr  (bus_addr),
    .bkpt_addr (bkpt_addr),
    .hit       (hit)
  );

  bkpt_regs #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .NBYTES(NBYTES), .SEL_W(SEL_W)
  ) u_regs (
    .clk       (clk),
    .rst_n     (rst_n),
    .reg_sel   (reg_sel),
    .reg_wr    (reg_wr),
    .reg_wdata (reg_wdata),
    .hit       (hit),
    .exit_flag (exit_flag),
    .reg_rdata (reg_rdata),
    .bkpt_addr (bkpt_addr),
    .enable    (enable),
    .active    (active),
    .act_rise  (act_rise),
    .exit_clr  (exit_clr)
  );

  bkpt_lpstat u_lpstat (
    .clk       (clk),
    .rst_n     (rst_n),
    .act_rise  (act_rise),
    .wait_mode (wait_mode),
    .stop_mode (stop_mode),
    .exit_clr  (exit_clr),
    .exit_flag (exit_flag)
  );

  assign brk_irq = active;
  assign lp_exit = exit_flag;

  // R8
  wait_match_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wait_mode && !stop_mode && enable && bus_valid && bus_addr == bkpt_addr) |=> brk_irq);

  // R9
  stop_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (stop_mode && !brk_irq && !(reg_wr && reg_sel == '0 && reg_wdata[1])) |=> !brk_irq);

  // R9
  stop_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (stop_mode && !reg_wr) |=> $stable(bkpt_addr));
endmodule

// File: tb/bkpt_unit_bench.sv
module bkpt_unit_bench;
  logic        clk = 1'b0;
  logic        rst_n;
  logic [1:0]  reg_sel;
  logic        reg_wr;
  logic [7:0]  reg_wdata;
  logic [7:0]  reg_rdata;
  logic [15:0] bus_addr;
  logic        bus_valid;
  logic        wait_mode;
  logic        stop_mode;
  logic        brk_irq;
  logic        lp_exit;

  int n_chk = 0;
  int n_bad = 0;
  bit done  = 1'b0;

  always #5 clk = ~clk;

  bkpt_unit u_bkpt_unit (
    .clk(clk), .rst_n(rst_n), .reg_sel(reg_sel), .reg_wr(reg_wr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .bus_addr(bus_addr),
    .bus_valid(bus_valid), .wait_mode(wait_mode), .stop_mode(stop_mode),
    .brk_irq(brk_irq), .lp_exit(lp_exit)
  );

  task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: got %h expected %h", req, act, exp);
    end
  endtask

  task automatic cyc();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic wr(input logic [1:0] s, input logic [7:0] d);
    reg_sel = s; reg_wdata = d; reg_wr = 1'b1;
    cyc();
    reg_wr = 1'b0;
  endtask

  task automatic rd(input logic [1:0] s, output logic [7:0] d);
    reg_sel = s;
    #1 d = reg_rdata;
  endtask

  task automatic t_reset();
    logic [7:0] d;
    for (int s = 0; s < 4; s++) begin
      rd(2'(s), d);
      chk("R2 reg after reset", 16'(d), 16'h00);
    end
    chk("R2 irq after reset", 16'(brk_irq), 16'h0);
    chk("R2 exit after reset", 16'(lp_exit), 16'h0);
  endtask

  task automatic t_regmap();
    logic [7:0] d;
    wr(2'd1, 8'h12);
    wr(2'd2, 8'h34);
    rd(2'd1, d); chk("R1 upper byte", 16'(d), 16'h12);
    rd(2'd2, d); chk("R1 lower byte", 16'(d), 16'h34);
    wr(2'd0, 8'hFF);
    rd(2'd0, d); chk("R1 ctrl unused bits", 16'(d), 16'h03);
    wr(2'd0, 8'h00);
    wr(2'd3, 8'hFF);
    rd(2'd3, d); chk("R10 write 1 to exit ignored", 16'(d), 16'h00);
  endtask

  task automatic t_match();
    logic [7:0] d;
    wr(2'd0, 8'h01);
    bus_addr = 16'h1234; bus_valid = 1'b1;
    #1 chk("R3 no irq before edge", 16'(brk_irq), 16'h0);
    cyc();
    bus_valid = 1'b0;
    chk("R3 match sets irq", 16'(brk_irq), 16'h1);
    rd(2'd0, d); chk("R11 flag reads back", 16'(d), 16'h03);
    chk("R10 no exit outside low power", 16'(lp_exit), 16'h0);
    wr(2'd0, 8'h01);
    chk("R11 irq drops with flag", 16'(brk_irq), 16'h0);
  endtask

  task automatic t_valid_gate();
    bus_addr = 16'h1234; bus_valid = 1'b0;
    cyc(); cyc();
    chk("R4 invalid strobe ignored", 16'(brk_irq), 16'h0);
    bus_addr = 16'h1235; bus_valid = 1'b1;
    cyc();
    chk("R4 low-byte mismatch", 16'(brk_irq), 16'h0);
    bus_addr = 16'h1334;
    cyc();
    bus_valid = 1'b0;
    chk("R4 high-byte mismatch", 16'(brk_irq), 16'h0);
  endtask

  task automatic t_enable_gate();
    wr(2'd0, 8'h00);
    bus_addr = 16'h1234; bus_valid = 1'b1;
    cyc(); cyc();
    bus_valid = 1'b0;
    chk("R7 disabled comparator", 16'(brk_irq), 16'h0);
  endtask

  task automatic t_force();
    wr(2'd0, 8'h02);
    chk("R5 forced break", 16'(brk_irq), 16'h1);
    cyc();
    chk("R6 flag holds idle", 16'(brk_irq), 16'h1);
    wr(2'd0, 8'h00);
    chk("R6 write 0 clears", 16'(brk_irq), 16'h0);
  endtask

  task automatic t_priority();
    wr(2'd0, 8'h01);
    bus_addr = 16'h1234; bus_valid = 1'b1;
    cyc();
    wr(2'd0, 8'h01);
    bus_valid = 1'b0;
    chk("R6 match beats clear", 16'(brk_irq), 16'h1);
    wr(2'd0, 8'h01);
    chk("R6 clear without match", 16'(brk_irq), 16'h0);
  endtask

  task automatic t_wait();
    logic [7:0] d;
    wait_mode = 1'b1;
    bus_addr = 16'h1234; bus_valid = 1'b1;
    cyc();
    bus_valid = 1'b0;
    chk("R8 match in wait", 16'(brk_irq), 16'h1);
    chk("R10 exit after wait break", 16'(lp_exit), 16'h1);
    wait_mode = 1'b0;
    wr(2'd0, 8'h01);
    rd(2'd3, d); chk("R10 exit survives flag clear", 16'(d), 16'h01);
    wr(2'd3, 8'h00);
    rd(2'd3, d); chk("R10 exit cleared by write 0", 16'(d), 16'h00);
  endtask

  task automatic t_stop();
    logic [7:0] d;
    stop_mode = 1'b1;
    bus_addr = 16'h1234; bus_valid = 1'b1;
    cyc(); cyc(); cyc();
    bus_valid = 1'b0;
    chk("R9 stop blocks match", 16'(brk_irq), 16'h0);
    chk("R9 no exit without break", 16'(lp_exit), 16'h0);
    rd(2'd1, d); chk("R9 upper kept in stop", 16'(d), 16'h12);
    rd(2'd2, d); chk("R9 lower kept in stop", 16'(d), 16'h34);
    rd(2'd0, d); chk("R9 ctrl kept in stop", 16'(d), 16'h01);
    wr(2'd0, 8'h03);
    chk("R5 forced in stop", 16'(brk_irq), 16'h1);
    chk("R10 exit after stop break", 16'(lp_exit), 16'h1);
    stop_mode = 1'b0;
    wr(2'd0, 8'h01);
    wr(2'd3, 8'h00);
    chk("R10 exit cleared after stop", 16'(lp_exit), 16'h0);
  endtask

  initial begin
    rst_n = 1'b0; reg_sel = '0; reg_wr = 1'b0; reg_wdata = '0;
    bus_addr = '0; bus_valid = 1'b0; wait_mode = 1'b0; stop_mode = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_regmap();
    t_match();
    t_valid_gate();
    t_enable_gate();
    t_force();
    t_priority();
    t_wait();
    t_stop();
    if (!done) begin
      done = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      n_chk++; n_bad++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end
endmodule